// File: doc/BRIEF.md
# Serial DAC Command Frame Generator

This block sits on the host side of a three-wire link to a dual-channel 12-bit converter. It takes one high-level request at a time over a valid/ready handshake and turns it into one or more 16-bit serial frames. The frames go out on an active-low chip select, a serial clock and a data line. A request can select the reference source, change the speed and power-down mode, write channel A, write channel B, or load both channels so that they update together.

Each frame carries two select bits (bit 15 and bit 12), a speed bit (bit 14), a power-down bit (bit 13) and a 12-bit payload (bits 11..0). The block keeps a stored copy of the speed bit, the power-down bit and the reference code. It places the stored speed and power-down bits into every frame, so a data write never changes the mode. All serial timing comes from parameters counted in system clock cycles: the clock half-period, the lead from chip select falling to the first clock fall, the trail after the last clock fall, and the gap between frames.

Top module: `dac_frame_gen`

## Requirements
- R1: Each frame is sent most-significant bit first. Exactly 16 falling serial-clock edges occur while chip select is low, and the receiver takes one bit on each falling edge.
- R2: The serial clock rests high. The first falling edge comes at least LEAD_CYC cycles after chip select falls, and the clock stays high during that time.
- R3: Within a frame, every high and every low phase of the serial clock lasts at least HALF_CYC cycles.
- R4: While chip select is low, the data line changes only in the cycle where the serial clock rises, so it is stable around each falling edge.
- R5: After the 16th falling edge, chip select stays low with the clock low for at least TRAIL_CYC cycles and at least HALF_CYC cycles. Chip select then rises in the same cycle in which the clock returns high.
- R6: Between two frames, chip select stays high for at least GAP_CYC cycles.
- R7: Operation code 0 (reference select) stores the 2-bit reference code and sends one control frame. In that frame bits 15 and 12 are 1, bits 14 and 13 hold the stored speed and power-down bits, bits 11..2 are 0 and bits 1..0 hold the new code. For example, fast mode with code 2 gives 0xD002.
- R8: Operation code 1 (mode set) stores the new speed and power-down bits. It sends one control frame that carries those new bits and the stored reference code.
- R9: Operation code 2 sends one frame {1, speed, power-down, 0, A value}. Operation code 3 sends one frame {0, speed, power-down, 0, B value}. Both use the stored mode bits.
- R10: Operation code 4 sends three frames in this order: a control frame built from the stored state, a buffer frame {0, speed, power-down, 1, B value}, then a channel-A frame {1, speed, power-down, 0, A value}.
- R11: Ready falls in the cycle after a request with a valid operation code is accepted, and busy rises with it. Ready returns only after the last frame's inter-frame gap has passed. Requests offered while ready is low are ignored.
- R12: Operation codes 5 to 7 are accepted, produce no frame and leave ready high.
- R13: After reset, chip select and the serial clock are high, data is 0, ready is high, busy is low, and the stored speed, power-down and reference code are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 3 | Operation code (0 ref, 1 mode, 2 write A, 3 write B, 4 paired load) |
| req_ref | input | 2 | Reference code for operation 0 |
| req_fast | input | 1 | Speed bit for operation 1 |
| req_pdown | input | 1 | Power-down bit for operation 1 |
| req_a | input | 12 | Channel A value |
| req_b | input | 12 | Channel B value |
| busy | output | 1 | Frames of a request are pending or in flight |
| link_csn | output | 1 | Active-low chip select |
| link_sclk | output | 1 | Serial clock, idles high |
| link_sdo | output | 1 | Serial data, changes on clock rise |

## Verification
A wrong stored speed, power-down or reference bit shows up in bits 14, 13 or 1..0 of the next frame that is sent, which is at most one request later. A wrong bit counter or phase counter shows up within one frame, as a wrong number of falling edges or a phase that is too short. A wrong frame index in the paired load shows up as wrong frame order or wrong frame count before ready returns. A wrong handshake shows up as ready reopening before the gap has passed, or as frames for a request that arrived while the block was busy.

// File: rtl/dacfg_pkg.sv
package dacfg_pkg;
  localparam int FRAME_W    = 16;
  localparam int DATA_W     = 12;
  localparam int REF_W      = 2;
  localparam int OP_W       = 3;
  localparam int MAX_FRAMES = 3;

  typedef enum logic [OP_W-1:0] {
    OP_REF  = 3'd0,
    OP_MODE = 3'd1,
    OP_WR_A = 3'd2,
    OP_WR_B = 3'd3,
    OP_PAIR = 3'd4
  } op_e;

  // select bits sit at 15 and 12; mode bits at 14 and 13
  function automatic logic [FRAME_W-1:0] mk_frame(input logic sel_hi, input logic sel_lo,
                                                  input logic fast, input logic pd,
                                                  input logic [DATA_W-1:0] pay);
    return {sel_hi, fast, pd, sel_lo, pay};
  endfunction

  function automatic logic [FRAME_W-1:0] mk_ctl(input logic fast, input logic pd,
                                                input logic [REF_W-1:0] code);
    return mk_frame(1'b1, 1'b1, fast, pd, {{(DATA_W-REF_W){1'b0}}, code});
  endfunction
endpackage

// File: rtl/dacfg_seq.sv
module dacfg_seq
  import dacfg_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [OP_W-1:0]    req_op,
  input  logic [REF_W-1:0]   req_ref,
  input  logic               req_fast,
  input  logic               req_pdown,
  input  logic [DATA_W-1:0]  req_a,
  input  logic [DATA_W-1:0]  req_b,
  output logic               req_ready,
  output logic               busy,
  input  logic               frm_ready,
  output logic               frm_start,
  output logic [FRAME_W-1:0] frm_word
);
  localparam int IW = $clog2(MAX_FRAMES + 1);

  logic               fast_q, pd_q;
  logic [REF_W-1:0]   ref_q;
  logic               busy_q, start_q;
  logic [FRAME_W-1:0] word_q;
  logic [FRAME_W-1:0] q_word [MAX_FRAMES];
  logic [IW-1:0]      q_n, q_i;

  logic [FRAME_W-1:0] plan [MAX_FRAMES];
  logic [IW-1:0]      plan_n;
  logic               accept;

  assign accept    = req_valid && !busy_q;
  assign req_ready = !busy_q;
  assign busy      = busy_q;
  assign frm_start = start_q;
  assign frm_word  = word_q;

  always_comb begin
    for (int i = 0; i < MAX_FRAMES; i++) plan[i] = '0;
    plan_n = '0;
    case (req_op)
      OP_REF: begin
        plan[0] = mk_ctl(fast_q, pd_q, req_ref);
        plan_n  = IW'(1);
      end
      OP_MODE: begin
        plan[0] = mk_ctl(req_fast, req_pdown, ref_q);
        plan_n  = IW'(1);
      end
      OP_WR_A: begin
        plan[0] = mk_frame(1'b1, 1'b0, fast_q, pd_q, req_a);
        plan_n  = IW'(1);
      end
      OP_WR_B: begin
        plan[0] = mk_frame(1'b0, 1'b0, fast_q, pd_q, req_b);
        plan_n  = IW'(1);
      end
      OP_PAIR: begin
        plan[0] = mk_ctl(fast_q, pd_q, ref_q);
        plan[1] = mk_frame(1'b0, 1'b1, fast_q, pd_q, req_b);
        plan[2] = mk_frame(1'b1, 1'b0, fast_q, pd_q, req_a);
        plan_n  = IW'(3);
      end
      default: plan_n = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fast_q  <= 1'b0;
      pd_q    <= 1'b0;
      ref_q   <= '0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      word_q  <= '0;
      q_n     <= '0;
      q_i     <= '0;
      for (int i = 0; i < MAX_FRAMES; i++) q_word[i] <= '0;
    end else begin
      start_q <= 1'b0;
      if (accept) begin
        if (req_op == OP_REF)  ref_q <= req_ref;
        if (req_op == OP_MODE) begin
          fast_q <= req_fast;
          pd_q   <= req_pdown;
        end
        for (int i = 0; i < MAX_FRAMES; i++) q_word[i] <= plan[i];
        q_n    <= plan_n;
        q_i    <= '0;
        busy_q <= (plan_n != '0);
      end else if (busy_q && !start_q && frm_ready) begin
        if (q_i != q_n) begin
          word_q  <= q_word[q_i[IW-1:0]];
          start_q <= 1'b1;
          q_i     <= q_i + IW'(1);
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  // R11: a request with a defined code makes the block busy on the next cycle
  a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op <= 3'd4) |=> busy);
  // R12: an undefined code leaves the block idle
  a_r12_bad_op_idle: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op > 3'd4) |=> (req_ready && !busy));
endmodule

// File: rtl/dacfg_shifter.sv
module dacfg_shifter
  import dacfg_pkg::*;
#(
  parameter int HALF_CYC  = 5,
  parameter int LEAD_CYC  = 2,
  parameter int TRAIL_CYC = 2,
  parameter int GAP_CYC   = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [FRAME_W-1:0] word,
  output logic               idle,
  output logic               csn,
  output logic               sclk,
  output logic               sdo
);
  localparam int TAIL_CYC = (TRAIL_CYC > HALF_CYC) ? TRAIL_CYC : HALF_CYC;
  localparam int MAX_A    = (LEAD_CYC > HALF_CYC) ? LEAD_CYC : HALF_CYC;
  localparam int MAX_B    = (TAIL_CYC > GAP_CYC) ? TAIL_CYC : GAP_CYC;
  localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);
  localparam int BIT_W    = $clog2(FRAME_W);

  typedef enum logic [2:0] {S_IDLE, S_LEAD, S_LOW, S_HIGH, S_TAIL, S_GAP} st_e;

  st_e                st;
  logic [CNT_W-1:0]   cnt;
  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] sh;
  logic               csn_q, sclk_q, sdo_q;
  logic               last_bit;

  assign last_bit = (bit_q == BIT_W'(FRAME_W - 1));
  assign idle     = (st == S_IDLE);
  assign csn      = csn_q;
  assign sclk     = sclk_q;
  assign sdo      = sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= S_IDLE;
      cnt    <= '0;
      bit_q  <= '0;
      sh     <= '0;
      csn_q  <= 1'b1;
      sclk_q <= 1'b1;
      sdo_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          sh    <= word;
          sdo_q <= word[FRAME_W-1];
          csn_q <= 1'b0;
          bit_q <= '0;
          cnt   <= CNT_W'(LEAD_CYC - 1);
          st    <= S_LEAD;
        end
        S_LEAD, S_HIGH: begin
          if (cnt == '0) begin
            sclk_q <= 1'b0;
            st     <= last_bit ? S_TAIL : S_LOW;
            cnt    <= last_bit ? CNT_W'(TAIL_CYC - 1) : CNT_W'(HALF_CYC - 1);
          end else cnt <= cnt - CNT_W'(1);
        end
        S_LOW: begin
          if (cnt == '0) begin
            sclk_q <= 1'b1;
            sh     <= sh << 1;
            sdo_q  <= sh[FRAME_W-2];
            bit_q  <= bit_q + BIT_W'(1);
            cnt    <= CNT_W'(HALF_CYC - 1);
            st     <= S_HIGH;
          end else cnt <= cnt - CNT_W'(1);
        end
        S_TAIL: begin
          if (cnt == '0) begin
            csn_q  <= 1'b1;
            sclk_q <= 1'b1;
            sdo_q  <= 1'b0;
            cnt    <= CNT_W'(GAP_CYC - 1);
            st     <= S_GAP;
          end else cnt <= cnt - CNT_W'(1);
        end
        S_GAP: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - CNT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4: data holds steady through each low clock phase
  a_r4_sdo_steady_low: assert property (@(posedge clk) disable iff (rst)
    (!csn_q && !sclk_q && $past(!csn_q && !sclk_q)) |-> $stable(sdo_q));
  // R4: data moves only with a clock rise or the start of a frame
  a_r4_sdo_moves_on_rise: assert property (@(posedge clk) disable iff (rst)
    (!csn_q && !$stable(sdo_q)) |-> ($rose(sclk_q) || $fell(csn_q)));
  // R2: a falling clock edge only ever happens inside an open frame
  a_r2_fall_inside_frame: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk_q) |-> (!csn_q && $past(!csn_q)));
  // R5: chip select closes with the clock back at its rest level
  a_r5_close_clock_high: assert property (@(posedge clk) disable iff (rst)
    $rose(csn_q) |-> sclk_q);
endmodule

// File: rtl/dac_frame_gen.sv
module dac_frame_gen
  import dacfg_pkg::*;
#(
  parameter int HALF_CYC  = 5,
  parameter int LEAD_CYC  = 2,
  parameter int TRAIL_CYC = 2,
  parameter int GAP_CYC   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic [REF_W-1:0]  req_ref,
  input  logic              req_fast,
  input  logic              req_pdown,
  input  logic [DATA_W-1:0] req_a,
  input  logic [DATA_W-1:0] req_b,
  output logic              busy,
  output logic              link_csn,
  output logic              link_sclk,
  output logic              link_sdo
);
  logic               frm_ready, frm_start;
  logic [FRAME_W-1:0] frm_word;

  dacfg_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_ref   (req_ref),
    .req_fast  (req_fast),
    .req_pdown (req_pdown),
    .req_a     (req_a),
    .req_b     (req_b),
    .req_ready (req_ready),
    .busy      (busy),
    .frm_ready (frm_ready),
    .frm_start (frm_start),
    .frm_word  (frm_word)
  );

  dacfg_shifter #(
    .HALF_CYC  (HALF_CYC),
    .LEAD_CYC  (LEAD_CYC),
    .TRAIL_CYC (TRAIL_CYC),
    .GAP_CYC   (GAP_CYC)
  ) u_shift (
    .clk   (clk),
    .rst   (rst),
    .start (frm_start),
    .word  (frm_word),
    .idle  (frm_ready),
    .csn   (link_csn),
    .sclk  (link_sclk),
    .sdo   (link_sdo)
  );

  // R11: a frame launch never reaches a serialiser still working on the previous frame
  a_r11_launch_when_idle: assert property (@(posedge clk) disable iff (rst)
    frm_start |-> frm_ready);
endmodule

// File: tb/dac_frame_gen_tb.sv
module dac_frame_gen_tb;
  localparam int HALF  = 5;
  localparam int LEAD  = 2;
  localparam int TRAIL = 2;
  localparam int GAP   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [1:0] req_ref = '0;
  logic req_fast = 1'b0, req_pdown = 1'b0;
  logic [11:0] req_a = '0, req_b = '0;
  logic req_ready, busy, link_csn, link_sclk, link_sdo;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dac_frame_gen #(.HALF_CYC(HALF), .LEAD_CYC(LEAD), .TRAIL_CYC(TRAIL), .GAP_CYC(GAP)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_ref(req_ref), .req_fast(req_fast), .req_pdown(req_pdown), .req_a(req_a), .req_b(req_b),
    .busy(busy), .link_csn(link_csn), .link_sclk(link_sclk), .link_sdo(link_sdo));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // link monitor: captures frames and checks timing
  logic [15:0] cap [16];
  int cap_n = 0;
  logic p_csn = 1'b1, p_sclk = 1'b1, p_sdo = 1'b0, p_ready = 1'b1;
  int ph_len = 0, nfall = 0, since_rise = 1000;
  logic [15:0] shr = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_csn && !link_csn) begin
        chk(since_rise >= GAP, "R6 gap", since_rise, GAP);
        chk(link_sclk == 1'b1, "R2 clock rests high", link_sclk, 1);
        nfall = 0; ph_len = 1; shr = '0;
      end else if (!link_csn) begin
        if (link_sclk != p_sclk) begin
          if (!link_sclk) begin
            if (nfall == 0) chk(ph_len >= LEAD, "R2 lead", ph_len, LEAD);
            else chk(ph_len >= HALF, "R3 high phase", ph_len, HALF);
            shr = {shr[14:0], link_sdo};
            nfall++;
          end else chk(ph_len >= HALF, "R3 low phase", ph_len, HALF);
          ph_len = 1;
        end else ph_len++;
        if (link_sdo != p_sdo && !(link_sclk && !p_sclk))
          chk(1'b0, "R4 data moved off rise", link_sdo, p_sdo);
      end else if (!p_csn && link_csn) begin
        chk(nfall == 16, "R1 falling edges per frame", nfall, 16);
        chk(!p_sclk && ph_len >= TRAIL && ph_len >= HALF, "R5 trail", ph_len, TRAIL);
        chk(link_sclk == 1'b1, "R5 clock high at close", link_sclk, 1);
        if (cap_n < 16) cap[cap_n] = shr;
        cap_n++;
        since_rise = 1;
      end else since_rise++;
      if (req_ready && !p_ready)
        chk(since_rise >= GAP, "R11 ready after gap", since_rise, GAP);
      p_csn = link_csn; p_sclk = link_sclk; p_sdo = link_sdo; p_ready = req_ready;
    end
  end

  task automatic issue(input logic [2:0] op, input logic [1:0] rc, input logic f, input logic pd,
                       input logic [11:0] a, input logic [11:0] b);
    cap_n = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_ref = rc; req_fast = f; req_pdown = pd; req_a = a; req_b = b;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000 && !req_ready; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(link_csn == 1 && link_sclk == 1 && link_sdo == 0, "R13 link idle",
        {link_csn, link_sclk, link_sdo}, 3'b110);
    chk(req_ready == 1 && busy == 0, "R13 ready idle", {req_ready, busy}, 2'b10);
  endtask

  task automatic t_first_write_a();
    issue(3'd2, 2'd0, 1'b0, 1'b0, 12'hABC, 12'h000);
    chk(!req_ready && busy, "R11 busy after accept", {req_ready, busy}, 2'b01);
    wait_done();
    chk(cap_n == 1, "R9 one frame", cap_n, 1);
    chk(cap[0] == 16'h8ABC, "R13 mode zero after reset / R9 A frame", cap[0], 16'h8ABC);
  endtask

  task automatic t_ref();
    issue(3'd0, 2'd2, 1'b1, 1'b1, 12'hFFF, 12'hFFF);
    wait_done();
    chk(cap_n == 1 && cap[0] == 16'h9002, "R7 reference frame", cap[0], 16'h9002);
  endtask

  task automatic t_mode_fast();
    issue(3'd1, 2'd0, 1'b1, 1'b0, 12'h000, 12'h000);
    wait_done();
    chk(cap_n == 1 && cap[0] == 16'hD002, "R8 mode frame keeps ref", cap[0], 16'hD002);
  endtask

  task automatic t_write_b();
    issue(3'd3, 2'd0, 1'b0, 1'b1, 12'h555, 12'h123);
    wait_done();
    chk(cap_n == 1 && cap[0] == 16'hC123 - 16'h8000, "R9 B frame", cap[0], 16'h4123);
  endtask

  task automatic t_pair();
    issue(3'd4, 2'd0, 1'b0, 1'b0, 12'h456, 12'h789);
    wait_done();
    chk(cap_n == 3, "R10 three frames", cap_n, 3);
    chk(cap[0] == 16'hD002, "R10 control first", cap[0], 16'hD002);
    chk(cap[1] == 16'h5789, "R10 buffer second", cap[1], 16'h5789);
    chk(cap[2] == 16'hC456, "R10 channel A last", cap[2], 16'hC456);
  endtask

  task automatic t_powerdown();
    issue(3'd1, 2'd0, 1'b0, 1'b1, 12'h000, 12'h000);
    wait_done();
    chk(cap_n == 1 && cap[0] == 16'hB002, "R8 power-down frame", cap[0], 16'hB002);
    issue(3'd2, 2'd0, 1'b1, 1'b0, 12'hFFF, 12'h000);
    wait_done();
    chk(cap_n == 1 && cap[0] == 16'hAFFF, "R9 write keeps mode", cap[0], 16'hAFFF);
    issue(3'd0, 2'd3, 1'b0, 1'b0, 12'h000, 12'h000);
    wait_done();
    chk(cap_n == 1 && cap[0] == 16'hB003, "R7 code 3 frame", cap[0], 16'hB003);
  endtask

  task automatic t_busy_ignore();
    issue(3'd2, 2'd0, 1'b0, 1'b0, 12'h0F0, 12'h000);
    req_valid = 1'b1; req_op = 3'd4; req_a = 12'h111; req_b = 12'h222;
    repeat (5) @(negedge clk);
    req_valid = 1'b0;
    wait_done();
    chk(cap_n == 1 && cap[0] == 16'hA0F0, "R11 request during busy ignored", cap_n, 1);
  endtask

  task automatic t_bad_op();
    issue(3'd6, 2'd1, 1'b1, 1'b1, 12'h321, 12'h321);
    chk(req_ready && !busy, "R12 ready stays high", {req_ready, busy}, 2'b10);
    repeat (60) @(negedge clk);
    chk(cap_n == 0 && link_csn == 1, "R12 no frame", cap_n, 0);
    issue(3'd2, 2'd0, 1'b0, 1'b0, 12'h001, 12'h000);
    wait_done();
    chk(cap_n == 1 && cap[0] == 16'hA001, "R12 mode untouched", cap[0], 16'hA001);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_first_write_a();
    t_ref();
    t_mode_fast();
    t_write_b();
    t_pair();
    t_powerdown();
    t_busy_ignore();
    t_bad_op();
    repeat (10) @(negedge clk);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule